// File: doc/BRIEF.md
# Phase-Locked PWM Speed Regulator

This block drives a motor speed input with a pulse-width-modulated signal. The duty factor of that signal follows the phase error between incoming data frames and an internal frame reference. A free-running reference counter sets the expected frame position. A one-cycle frame-start strobe from the data path captures the counter value, read as a signed two's-complement phase error. Once per regulation interval, the last captured error is mapped to a new duty factor. The new duty factor then holds for the whole next interval.

The map is linear around a 50% duty factor at zero error and is clamped to about 9% and 91%. The interval is centred on the reference point. A frame later than half an interval therefore falls into the next interval as an early frame, and the map wraps as a sawtooth. A flag reports whether the last interval had a frame inside the clamp range. An override path from a frequency-deviation monitor can replace the output with a fixed level for whole intervals.

With the default parameters and a 6.144 MHz clock, one PWM period is 256 clocks (24 kHz). A regulation interval is 512 PWM periods, about 21.3 ms.

Top module: `psr_top`

## Requirements
- R1: While `rst_n` is low, `pwm_o` and `phase_valid_o` are low. From reset until the first interval update the duty factor is 2^(PWM_W-1) clocks, which is 50%.
- R2: The PWM period is 2^PWM_W clocks, and `pwm_o` is high for exactly `duty` clocks of each period. The duty factor and the override mode change only at an interval boundary, which is also a PWM period boundary.
- R3: The reference counter has PH_W = PWM_W+IVL_W bits and counts up from 0 after reset. A strobe sampled at a clock edge captures the counter value as a signed error, where 0 means on time and positive means late. An interval covers the counter values -2^(PH_W-1) to 2^(PH_W-1)-1. The update happens at the edge where the counter equals 2^(PH_W-1)-1, and a strobe on that same edge is still counted.
- R4: After an interval that contains a strobe, the new duty factor is MID + floor(err / 2^IVL_W), with MID = 2^(PWM_W-1).
- R5: The duty factor is clamped to the range LO = round(0.09·2^PWM_W) to HI = round(0.91·2^PWM_W).
- R6: After each update, `phase_valid_o` is 1 only if the interval contained a strobe and |err| <= (MID-LO)·2^IVL_W.
- R7: After an interval with no strobe, `phase_valid_o` is 0 and the duty factor keeps its previous value.
- R8: When an interval contains several strobes, only the last one sets the error.
- R9: A frame later than half an interval is captured in the next interval as an early frame. As the error crosses the interval edge, the duty factor jumps from HI to LO, which forms the sawtooth.
- R10: `ovr_active` is sampled at each update. When it is 1, `pwm_o` holds the forced level for the whole next interval. Normal PWM output returns after the next update that samples `ovr_active` as 0.
- R11: The forced level is high only when `ovr_high`=1 and `ovr_low`=0. In every other case it is low.
- R12: When `ovr_active` is 0 at the update, `ovr_high` and `ovr_low` have no effect on `pwm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking an incoming frame start |
| ovr_active | input | 1 | Override request from the frequency-deviation monitor |
| ovr_high | input | 1 | Override requests a high level |
| ovr_low | input | 1 | Override requests a low level (dominant) |
| pwm_o | output | 1 | PWM speed drive |
| phase_valid_o | output | 1 | The last interval held a strobe inside the clamp range |

## Verification
The phase map is tested with single strobes on time, moderately early and moderately late, and exactly at the clamp edges. These cases separate the slope and the floor rounding of negative errors from the clamp levels. Strobes just beyond the clamp edges and on the first and last cycle of the window separate the validity limit from the clamp, and also check the window boundaries. A pair of strobes on either side of the wrap point shows the sawtooth jump. Two strobes in one interval, an empty interval and every combination of the override inputs separate last-strobe selection, holding the duty factor, the priority of the forced level and the inputs that are ignored.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Source of the PWM output for the current interval
    typedef enum logic [1:0] {
        DRV_REG  = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_LOW  = 2'd2
    } drv_mode_e;

endpackage

// File: rtl/psr_refcnt.sv
module psr_refcnt #(
    parameter int PH_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] cnt,
    output logic            win_end
);
    // Last count of an interval window: largest positive signed value
    localparam logic [PH_W-1:0] LAST = {1'b0, {(PH_W-1){1'b1}}};

    logic [PH_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q + 1'b1;
        win_end = (cnt_q == LAST);
        cnt     = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/psr_phase_cap.sv
module psr_phase_cap #(
    parameter int PH_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic [PH_W-1:0] cnt,
    input  logic            win_end,
    output logic [PH_W-1:0] err_now,
    output logic            seen_now
);
    typedef struct packed {
        logic            seen;
        logic [PH_W-1:0] err;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        // a strobe in this cycle replaces any earlier one (last wins)
        err_now    = stb ? cnt : cap_q.err;
        seen_now   = stb | cap_q.seen;
        cap_d.err  = err_now;
        cap_d.seen = win_end ? 1'b0 : seen_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end
endmodule

// File: rtl/psr_duty_map.sv
module psr_duty_map #(
    parameter  int PWM_W = 8,
    parameter  int IVL_W = 9,
    localparam int PH_W  = PWM_W + IVL_W
) (
    input  logic [PH_W-1:0]  err,
    output logic [PWM_W-1:0] duty,
    output logic             in_range
);
    localparam int PER = 1 << PWM_W;
    localparam int MID = PER / 2;
    localparam int LO  = (PER * 9 + 50) / 100;
    localparam int HI  = (PER * 91 + 50) / 100;
    localparam int LIM = (MID - LO) << IVL_W;

    localparam logic signed [PH_W+1:0] MID_S = (PH_W+2)'(MID);
    localparam logic signed [PH_W+1:0] LO_S  = (PH_W+2)'(LO);
    localparam logic signed [PH_W+1:0] HI_S  = (PH_W+2)'(HI);
    localparam logic signed [PH_W:0]   LIM_S = (PH_W+1)'(LIM);

    logic signed [PH_W-1:0] e_s;
    logic signed [PH_W-1:0] step;
    logic signed [PH_W+1:0] raw;
    logic signed [PH_W:0]   e_x;

    always_comb begin
        e_s  = $signed(err);
        step = e_s >>> IVL_W;                       // floor division
        raw  = MID_S + $signed({{2{step[PH_W-1]}}, step});
        e_x  = $signed({e_s[PH_W-1], e_s});
        in_range = (e_x >= -LIM_S) && (e_x <= LIM_S);
        if (raw < LO_S)      duty = PWM_W'(LO);
        else if (raw > HI_S) duty = PWM_W'(HI);
        else                 duty = raw[PWM_W-1:0];
    end
endmodule

// File: rtl/psr_pwm_gen.sv
module psr_pwm_gen #(
    parameter int PWM_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PWM_W-1:0]    cnt_lo,
    input  logic [PWM_W-1:0]    duty,
    input  psr_pkg::drv_mode_e  mode,
    output logic                pwm
);
    logic pwm_d, pwm_q;

    always_comb begin
        unique case (mode)
            psr_pkg::DRV_HIGH: pwm_d = 1'b1;
            psr_pkg::DRV_LOW:  pwm_d = 1'b0;
            default:           pwm_d = (cnt_lo < duty);
        endcase
        pwm = pwm_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end
endmodule

// File: rtl/psr_top.sv
module psr_top #(
    parameter int PWM_W = 8,
    parameter int IVL_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic ovr_active,
    input  logic ovr_high,
    input  logic ovr_low,
    output logic pwm_o,
    output logic phase_valid_o
);
    localparam int PH_W = PWM_W + IVL_W;
    localparam int MID  = (1 << PWM_W) / 2;

    typedef struct packed {
        logic [PWM_W-1:0]   duty;
        logic               valid;
        psr_pkg::drv_mode_e mode;
    } reg_t;

    reg_t st_d, st_q;

    logic [PH_W-1:0]    cnt;
    logic               win_end;
    logic [PH_W-1:0]    err_now;
    logic               seen_now;
    logic [PWM_W-1:0]   duty_new;
    logic               in_range;
    logic [PWM_W-1:0]   duty_cur;
    psr_pkg::drv_mode_e mode_cur;

    psr_refcnt #(.PH_W(PH_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .win_end(win_end)
    );

    psr_phase_cap #(.PH_W(PH_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .stb(frame_stb), .cnt(cnt),
        .win_end(win_end), .err_now(err_now), .seen_now(seen_now)
    );

    psr_duty_map #(.PWM_W(PWM_W), .IVL_W(IVL_W)) u_map (
        .err(err_now), .duty(duty_new), .in_range(in_range)
    );

    always_comb begin
        st_d = st_q;
        if (win_end) begin
            st_d.valid = seen_now && in_range;
            if (seen_now) st_d.duty = duty_new;
            if (!ovr_active)             st_d.mode = psr_pkg::DRV_REG;
            else if (ovr_high && !ovr_low) st_d.mode = psr_pkg::DRV_HIGH;
            else                         st_d.mode = psr_pkg::DRV_LOW;
        end
        duty_cur      = st_q.duty;
        mode_cur      = st_q.mode;
        phase_valid_o = st_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.duty  <= PWM_W'(MID);
            st_q.valid <= 1'b0;
            st_q.mode  <= psr_pkg::DRV_REG;
        end else begin
            st_q <= st_d;
        end
    end

    psr_pwm_gen #(.PWM_W(PWM_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .cnt_lo(cnt[PWM_W-1:0]),
        .duty(duty_cur), .mode(mode_cur), .pwm(pwm_o)
    );
endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
    parameter  int PWM_W = 8,
    parameter  int IVL_W = 9,
    localparam int PH_W  = PWM_W + IVL_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PH_W-1:0]    cnt,
    input logic [PWM_W-1:0]   duty,
    input logic               valid,
    input psr_pkg::drv_mode_e mode,
    input logic               pwm
);
    localparam int PER = 1 << PWM_W;
    localparam int LO  = (PER * 9 + 50) / 100;
    localparam int HI  = (PER * 91 + 50) / 100;
    localparam logic [PH_W-1:0] FIRST = {1'b1, {(PH_W-1){1'b0}}};

    // R2
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != FIRST) |-> $stable(duty));

    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != FIRST) |-> $stable(valid));

    // R5
    duty_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(duty) >= LO) && (int'(duty) <= HI));

    // R10
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == psr_pkg::DRV_HIGH) |-> pwm);

    // R11
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == psr_pkg::DRV_LOW) |-> !pwm);
endmodule

bind psr_top psr_chk #(.PWM_W(PWM_W), .IVL_W(IVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .duty(duty_cur),
    .valid(phase_valid_o), .mode(mode_cur), .pwm(pwm_o)
);

// File: tb/tb_psr_top.sv
module tb_psr_top;
    localparam int CLK_P = 10;
    localparam int PWM_W = 6;
    localparam int IVL_W = 3;
    localparam int PER   = 1 << PWM_W;
    localparam int N     = 1 << (PWM_W + IVL_W);
    localparam int HALF  = N / 2;
    localparam int MID   = PER / 2;
    localparam int LO    = (PER * 9 + 50) / 100;
    localparam int HI    = (PER * 91 + 50) / 100;
    localparam int LIM   = (MID - LO) << IVL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic ovr_active = 1'b0, ovr_high = 1'b0, ovr_low = 1'b0;
    logic pwm_o, phase_valid_o;

    int cyc;
    int checks = 0;
    int fails = 0;
    int cur_duty = MID;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    psr_top #(.PWM_W(PWM_W), .IVL_W(IVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .ovr_active(ovr_active), .ovr_high(ovr_high), .ovr_low(ovr_low),
        .pwm_o(pwm_o), .phase_valid_o(phase_valid_o)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_duty(int e);
        int v;
        v = MID + (e >>> IVL_W);
        if (v < LO) v = LO;
        if (v > HI) v = HI;
        return v;
    endfunction

    function automatic bit exp_valid(int e);
        return (e >= -LIM) && (e <= LIM);
    endfunction

    task automatic wait_idx(int p);
        @(negedge clk);
        while ((cyc % N) != p) @(negedge clk);
    endtask

    // Runs one full interval from its first cycle; returns at next interval start.
    task automatic stim_window(int nstb, int e1, int e2, bit act, bit hi, bit lo);
        ovr_active = act; ovr_high = hi; ovr_low = lo;
        for (int k = 0; k < N; k++) begin
            int idx, pos;
            idx = cyc % N;
            pos = (idx >= HALF) ? idx - N : idx;
            frame_stb = ((nstb >= 1) && (pos == e1)) || ((nstb >= 2) && (pos == e2));
            @(negedge clk);
        end
        frame_stb = 1'b0;
        ovr_active = 1'b0; ovr_high = 1'b0; ovr_low = 1'b0;
    endtask

    task automatic measure(output int highs);
        highs = 0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < PER; k++) begin
            if (pwm_o) highs++;
            @(negedge clk);
        end
    endtask

    task automatic run_phase(string req, int e);
        int h, ed;
        bit ev;
        ed = exp_duty(e);
        ev = exp_valid(e);
        stim_window(1, e, 0, 0, 0, 0);
        check(phase_valid_o == ev, req, "phase_valid", phase_valid_o, ev);
        measure(h);
        check(h == ed, req, "duty", h, ed);
        cur_duty = ed;
        wait_idx(HALF);
    endtask

    task automatic test_reset();
        int h;
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1", "pwm in reset", pwm_o, 0);
        check(phase_valid_o == 1'b0, "R1", "valid in reset", phase_valid_o, 0);
        rst_n = 1'b1;
        wait_idx(HALF);
        check(phase_valid_o == 1'b0, "R1", "valid after first update", phase_valid_o, 0);
        measure(h);
        check(h == MID, "R1", "reset duty", h, MID);
        wait_idx(HALF);
    endtask

    task automatic test_period();
        int t0, t1, h1, h2;
        bit prev;
        prev = pwm_o;
        @(negedge clk);
        while (!(pwm_o && !prev)) begin prev = pwm_o; @(negedge clk); end
        t0 = cyc;
        prev = pwm_o;
        @(negedge clk);
        while (!(pwm_o && !prev)) begin prev = pwm_o; @(negedge clk); end
        t1 = cyc;
        check((t1 - t0) == PER, "R2", "pwm period", t1 - t0, PER);
        measure(h1);
        repeat (100) @(negedge clk);
        measure(h2);
        check(h1 == cur_duty, "R2", "highs early in interval", h1, cur_duty);
        check(h2 == cur_duty, "R2", "highs later in interval", h2, cur_duty);
        wait_idx(HALF);
    endtask

    task automatic test_last_wins();
        int h, ed;
        ed = exp_duty(40);
        stim_window(2, -50, 40, 0, 0, 0);
        check(phase_valid_o == 1'b1, "R8", "valid", phase_valid_o, 1);
        measure(h);
        check(h == ed, "R8", "last strobe duty", h, ed);
        cur_duty = ed;
        wait_idx(HALF);
    endtask

    task automatic test_hold();
        int h;
        // previous interval had no strobe
        check(phase_valid_o == 1'b0, "R7", "valid after empty interval", phase_valid_o, 0);
        measure(h);
        check(h == cur_duty, "R7", "held duty", h, cur_duty);
        wait_idx(HALF);
    endtask

    task automatic run_ovr(string req, bit act, bit hi, bit lo, int exp_h);
        int h;
        stim_window(0, 0, 0, act, hi, lo);
        measure(h);
        check(h == exp_h, req, "forced interval highs", h, exp_h);
        wait_idx(HALF);
        measure(h);
        check(h == cur_duty, "R10", "normal after override", h, cur_duty);
        wait_idx(HALF);
    endtask

    initial begin
        test_reset();
        run_phase("R3 R4 on time", 0);
        test_period();
        run_phase("R4 late", 100);
        run_phase("R4 early", -100);
        run_phase("R5 R6 upper edge", LIM);
        run_phase("R5 R6 lower edge", -LIM);
        run_phase("R6 beyond upper", LIM + 1);
        run_phase("R5 R6 beyond lower", -240);
        run_phase("R3 last window cycle", HALF - 1);
        run_phase("R3 first window cycle", -HALF);
        run_phase("R9 before wrap", HALF - 6);
        run_phase("R9 after wrap", -(HALF - 4));
        test_last_wins();
        test_hold();
        run_ovr("R10 force high", 1'b1, 1'b1, 1'b0, PER);
        run_ovr("R10 force low", 1'b1, 1'b0, 1'b1, 0);
        run_ovr("R11 both set", 1'b1, 1'b1, 1'b1, 0);
        run_ovr("R11 neither set", 1'b1, 1'b0, 1'b0, 0);
        run_ovr("R12 inactive", 1'b0, 1'b1, 1'b1, cur_duty);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule